// File: doc/BRIEF.md
# Conditional Control-Transfer Resolver

This block settles the direction and destination of a conditional control transfer late in an integer pipeline. Each accepted request names one of four families: a branch on the integer flags, a branch on a floating-point compare result, a branch on the contents of a general register, or a trap that fires on an integer-flag condition. The block combines the request's operands with a 4-bit condition selector and returns the resolved direction and the next fetch address. For branches it also returns a misprediction flag, found by comparing against the predictor's guess, and a strobe that tells the predictor to train. For trap requests it returns a trap request and a trap number.

The integer flags arrive packed in one word that carries two flag nibbles: a narrow set at bit 0 and a wide set higher up. A per-request select picks one of them. Results are registered, so they appear one clock after a valid request and hold until the next one.

Top module: `cond_xfer_resolver`

## Requirements
- R1: Kind encoding on req_kind: 0 integer-flag branch, 1 floating-point branch, 2 register branch, 3 conditional trap. The flag nibble holds carry at bit 0, overflow at bit 1, zero at bit 2 and negative at bit 3. It is read from cc_word[3:0] when wide_flags is 0 and from cc_word[WIDE_SHIFT+3:WIDE_SHIFT] when it is 1. Integer selectors: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V, 8 always, 9 !Z, 10 !(Z|(N^V)), 11 !(N^V), 12 !(C|Z), 13 !C, 14 !N, 15 !V.
- R2: fcmp encodes 0 equal, 1 less, 2 greater, 3 unordered. Floating selectors, as the set of results that take the branch: 0 none, 1 L|G|U, 2 L|G, 3 U|L, 4 L, 5 U|G, 6 G, 7 U, 8 all, 9 E, 10 U|E, 11 G|E, 12 U|G|E, 13 L|E, 14 U|L|E, 15 E|L|G.
- R3: A register branch uses cond_sel[2:0] and compares reg_val, taken as signed, with zero: 1 equal, 2 less-or-equal, 3 less, 5 not equal, 6 greater, 7 greater-or-equal. Codes 0 and 4 are never taken, and cond_sel[3] is ignored.
- R4: For the three branch kinds, a taken result gives res_next_pc = pc + 4*sign-extended disp, and a not-taken result gives pc + 8. A trap request gives pc + 4.
- R5: res_mispredict is 1 exactly when a branch's resolved direction differs from pred_taken. It is 0 for a trap request.
- R6: res_bp_update is 1 for every register branch and for integer or floating branches whose selector is not 0. It is 0 for selector 0 in those two families and for trap requests.
- R7: A trap request raises res_trap only when its integer condition holds. res_trap_num = TRAP_BASE + trap_a + (trap_use_imm ? sign-extended trap_imm : trap_b), taken modulo 2^TRAP_W.
- R8: Results appear on the clock edge after a request with req_valid high. res_valid is high for exactly that one cycle. All other outputs hold their values while no request is accepted.
- R9: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier |
| req_kind | input | 2 | Family of the request |
| cond_sel | input | 4 | Condition selector |
| wide_flags | input | 1 | Use the wide flag nibble |
| cc_word | input | CC_W | Packed integer flags |
| fcmp | input | 2 | Floating compare result |
| reg_val | input | XLEN | Register tested by register branches |
| pc | input | ADDR_W | Address of the transfer |
| disp | input | DISP_W | Signed word displacement |
| pred_taken | input | 1 | Predicted direction |
| trap_a | input | XLEN | First trap operand |
| trap_b | input | XLEN | Second trap operand |
| trap_imm | input | IMM_W | Signed trap immediate |
| trap_use_imm | input | 1 | Select immediate instead of trap_b |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Resolved direction or trap condition |
| res_next_pc | output | ADDR_W | Next fetch address |
| res_mispredict | output | 1 | Prediction was wrong |
| res_bp_update | output | 1 | Predictor training strobe |
| res_trap | output | 1 | Trap request |
| res_trap_num | output | TRAP_W | Trap number |

## Verification
On every cycle the assertions check the one-cycle result strobe, the holding of results between requests, and the link between misprediction and the registered direction and prediction. They also check the not-taken address, and that the never selectors, register codes 0 and 4 and trap requests produce no taken branch, no training and no misprediction where the rules forbid them. Whether each of the 48 condition encodings picks the right flags, that the wide and narrow nibbles are told apart, the taken address with negative displacements, and trap-number arithmetic with either operand are shown only by the bench's directed and random scenarios against its own reference functions.

// File: rtl/cxr_pkg.sv
package cxr_pkg;
   typedef enum logic [1:0] {
      KIND_INT  = 2'd0,
      KIND_FP   = 2'd1,
      KIND_REG  = 2'd2,
      KIND_TRAP = 2'd3
   } xfer_kind_e;

   localparam logic [3:0] SEL_NEVER = 4'd0;

   // Bit positions inside one integer flag nibble.
   localparam int FLG_C = 0;
   localparam int FLG_V = 1;
   localparam int FLG_Z = 2;
   localparam int FLG_N = 3;

   // Set of compare results (bit index = fcmp value: E=0, L=1, G=2, U=3)
   // accepted by the lower eight floating selectors; the upper eight are
   // their complements.
   function automatic logic [3:0] fp_base_mask(input logic [2:0] s);
      case (s)
         3'd0:    return 4'b0000;
         3'd1:    return 4'b1110;
         3'd2:    return 4'b0110;
         3'd3:    return 4'b1010;
         3'd4:    return 4'b0010;
         3'd5:    return 4'b1100;
         3'd6:    return 4'b0100;
         default: return 4'b1000;
      endcase
   endfunction
endpackage

// File: rtl/cxr_int_cond.sv
module cxr_int_cond #(
   parameter int CC_W       = 32,
   parameter int WIDE_SHIFT = 16
) (
   input  logic [CC_W-1:0] cc_word,
   input  logic            wide_flags,
   input  logic [3:0]      sel,
   output logic            hold
);
   import cxr_pkg::*;

   localparam int NSETS = 2;

   if (WIDE_SHIFT + 4 > CC_W) begin : g_bad_shift
      $error("cxr_int_cond: wide flag nibble exceeds CC_W");
   end
   if (WIDE_SHIFT < 4) begin : g_bad_overlap
      $error("cxr_int_cond: flag nibbles overlap");
   end

   logic [3:0] nib [NSETS];
   logic [3:0] flags;
   logic       base;
   logic       unused_cc;

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      localparam int OFS = g * WIDE_SHIFT;
      assign nib[g] = cc_word[OFS +: 4];
   end

   assign flags     = wide_flags ? nib[1] : nib[0];
   assign unused_cc = ^cc_word;

   always_comb begin
      case (sel[2:0])
         3'd0:    base = 1'b0;
         3'd1:    base = flags[FLG_Z];
         3'd2:    base = flags[FLG_Z] | (flags[FLG_N] ^ flags[FLG_V]);
         3'd3:    base = flags[FLG_N] ^ flags[FLG_V];
         3'd4:    base = flags[FLG_C] | flags[FLG_Z];
         3'd5:    base = flags[FLG_C];
         3'd6:    base = flags[FLG_N];
         default: base = flags[FLG_V];
      endcase
   end

   // Upper half of the selector space inverts the lower half.
   assign hold = base ^ sel[3];
endmodule

// File: rtl/cxr_fp_cond.sv
module cxr_fp_cond (
   input  logic [1:0] fcmp,
   input  logic [3:0] sel,
   output logic       hold
);
   import cxr_pkg::*;

   logic [3:0] mask;

   assign mask = fp_base_mask(sel[2:0]) ^ {4{sel[3]}};
   assign hold = mask[fcmp];
endmodule

// File: rtl/cxr_reg_cond.sv
module cxr_reg_cond #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] reg_val,
   input  logic [2:0]      sel,
   output logic            hold
);
   logic is_zero;
   logic is_neg;
   logic base;

   assign is_zero = (reg_val == '0);
   assign is_neg  = reg_val[XLEN-1];

   always_comb begin
      case (sel[1:0])
         2'd1:    base = is_zero;
         2'd2:    base = is_zero | is_neg;
         2'd3:    base = is_neg;
         default: base = 1'b0;
      endcase
   end

   // Codes with bit 2 set are the complements; codes 0 and 4 never hold.
   assign hold = (sel[1:0] != 2'd0) & (base ^ sel[2]);
endmodule

// File: rtl/cond_xfer_resolver.sv
module cond_xfer_resolver #(
   parameter int XLEN       = 64,
   parameter int CC_W       = 32,
   parameter int WIDE_SHIFT = 16,
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 22,
   parameter int IMM_W      = 13,
   parameter int TRAP_W     = 8,
   parameter int TRAP_BASE  = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [3:0]        cond_sel,
   input  logic              wide_flags,
   input  logic [CC_W-1:0]   cc_word,
   input  logic [1:0]        fcmp,
   input  logic [XLEN-1:0]   reg_val,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              pred_taken,
   input  logic [XLEN-1:0]   trap_a,
   input  logic [XLEN-1:0]   trap_b,
   input  logic [IMM_W-1:0]  trap_imm,
   input  logic              trap_use_imm,
   output logic              res_valid,
   output logic              res_taken,
   output logic [ADDR_W-1:0] res_next_pc,
   output logic              res_mispredict,
   output logic              res_bp_update,
   output logic              res_trap,
   output logic [TRAP_W-1:0] res_trap_num
);
   import cxr_pkg::*;

   localparam logic [ADDR_W-1:0] STEP_SEQ  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] STEP_SKIP = ADDR_W'(8);
   localparam logic [TRAP_W-1:0] TBASE     = TRAP_W'(TRAP_BASE);

   if (TRAP_W > XLEN) begin : g_bad_trapw
      $error("cond_xfer_resolver: TRAP_W wider than XLEN");
   end
   if (IMM_W > XLEN) begin : g_bad_immw
      $error("cond_xfer_resolver: IMM_W wider than XLEN");
   end

   xfer_kind_e kind;
   assign kind = xfer_kind_e'(req_kind);

   // ---------------- condition evaluators ----------------
   logic int_hold, fp_hold, reg_hold;

   cxr_int_cond #(.CC_W(CC_W), .WIDE_SHIFT(WIDE_SHIFT)) u_int (
      .cc_word    (cc_word),
      .wide_flags (wide_flags),
      .sel        (cond_sel),
      .hold       (int_hold)
   );

   cxr_fp_cond u_fp (
      .fcmp (fcmp),
      .sel  (cond_sel),
      .hold (fp_hold)
   );

   cxr_reg_cond #(.XLEN(XLEN)) u_reg (
      .reg_val (reg_val),
      .sel     (cond_sel[2:0]),
      .hold    (reg_hold)
   );

   // ---------------- displacement sign extension ----------------
   logic [ADDR_W-1:0] disp_ext;
   logic              unused_disp;

   if (DISP_W < ADDR_W) begin : g_disp_narrow
      assign disp_ext    = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      assign unused_disp = 1'b0;
   end else begin : g_disp_wide
      assign disp_ext    = disp[ADDR_W-1:0];
      assign unused_disp = ^disp;
   end

   // ---------------- trap operand ----------------
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] trap_opnd;
   logic [XLEN-1:0] trap_sum;
   logic            unused_sum;

   if (IMM_W < XLEN) begin : g_imm_ext
      assign imm_ext = {{(XLEN-IMM_W){trap_imm[IMM_W-1]}}, trap_imm};
   end else begin : g_imm_full
      assign imm_ext = trap_imm;
   end

   assign trap_opnd  = trap_use_imm ? imm_ext : trap_b;
   assign trap_sum   = trap_a + trap_opnd;
   assign unused_sum = ^trap_sum;

   // ---------------- resolution ----------------
   logic              taken_c;
   logic              is_branch;
   logic              train_c;
   logic [ADDR_W-1:0] target_c;
   logic [ADDR_W-1:0] next_pc_c;
   logic [TRAP_W-1:0] trap_num_c;

   always_comb begin
      case (kind)
         KIND_FP:  taken_c = fp_hold;
         KIND_REG: taken_c = reg_hold;
         default:  taken_c = int_hold;
      endcase
   end

   assign is_branch = (kind != KIND_TRAP);

   always_comb begin
      case (kind)
         KIND_REG:  train_c = 1'b1;
         KIND_TRAP: train_c = 1'b0;
         default:   train_c = (cond_sel != SEL_NEVER);
      endcase
   end

   assign target_c = pc + (disp_ext << 2);

   always_comb begin
      if (!is_branch)   next_pc_c = pc + STEP_SEQ;
      else if (taken_c) next_pc_c = target_c;
      else              next_pc_c = pc + STEP_SKIP;
   end

   assign trap_num_c = TBASE + trap_sum[TRAP_W-1:0];

   // ---------------- result registers ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid      <= 1'b0;
         res_taken      <= 1'b0;
         res_next_pc    <= '0;
         res_mispredict <= 1'b0;
         res_bp_update  <= 1'b0;
         res_trap       <= 1'b0;
         res_trap_num   <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_taken      <= taken_c;
            res_next_pc    <= next_pc_c;
            res_mispredict <= is_branch & (taken_c ^ pred_taken);
            res_bp_update  <= train_c;
            res_trap       <= ~is_branch & taken_c;
            res_trap_num   <= trap_num_c;
         end
      end
   end
endmodule

// File: rtl/cxr_checker.sv
module cxr_checker #(
   parameter int ADDR_W = 32,
   parameter int TRAP_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [3:0]        cond_sel,
   input logic [ADDR_W-1:0] pc,
   input logic              pred_taken,
   input logic              res_valid,
   input logic              res_taken,
   input logic [ADDR_W-1:0] res_next_pc,
   input logic              res_mispredict,
   input logic              res_bp_update,
   input logic              res_trap,
   input logic [TRAP_W-1:0] res_trap_num
);
   logic had_reset = 1'b0;
   always_ff @(posedge clk) if (rst) had_reset <= 1'b1;

   // R8: strobe follows an accepted request by one cycle
   a_r8_strobe: assert property (@(posedge clk) disable iff (rst || !had_reset)
      res_valid == $past(req_valid));

   // R8: results hold while nothing is accepted
   a_r8_hold: assert property (@(posedge clk) disable iff (rst || !had_reset)
      !$past(req_valid) |-> $stable(res_taken) && $stable(res_next_pc) &&
      $stable(res_mispredict) && $stable(res_bp_update) &&
      $stable(res_trap) && $stable(res_trap_num));

   // R5: misprediction reflects direction against prediction
   a_r5_mispredict: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $past(req_valid) && $past(req_kind) != 2'd3 |->
      res_mispredict == (res_taken != $past(pred_taken)));

   // R4: not-taken branch falls through by two words
   a_r4_fallthrough: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $past(req_valid) && $past(req_kind) != 2'd3 && !res_taken |->
      res_next_pc == $past(pc) + ADDR_W'(8));

   // R6: never selector in flag families neither takes nor trains
   a_r6_never: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $past(req_valid) && $past(req_kind) < 2'd2 && $past(cond_sel) == 4'd0 |->
      !res_taken && !res_bp_update);

   // R3: register codes 0 and 4 are never taken but still train
   a_r3_dead_codes: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $past(req_valid) && $past(req_kind) == 2'd2 && $past(cond_sel[1:0]) == 2'd0 |->
      !res_taken && res_bp_update);

   // R7: trap request only from a trap kind, and it carries no branch side effects
   a_r7_trap_kind: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $past(req_valid) && $past(req_kind) == 2'd3 |->
      res_trap == res_taken && !res_mispredict && !res_bp_update);

   a_r7_trap_origin: assert property (@(posedge clk) disable iff (rst || !had_reset)
      $rose(res_trap) |-> $past(req_valid) && $past(req_kind) == 2'd3);
endmodule

bind cond_xfer_resolver cxr_checker #(.ADDR_W(ADDR_W), .TRAP_W(TRAP_W)) u_chk (.*);

// File: tb/cond_xfer_resolver_test.sv
`timescale 1ns/1ps
module cond_xfer_resolver_test;
   localparam int XLEN = 64, CC_W = 32, WS = 16, AW = 32, DW = 22, IW = 13, TW = 8, TB = 128;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst, req_valid, wide_flags, pred_taken, trap_use_imm;
   logic [1:0] req_kind, fcmp;
   logic [3:0] cond_sel;
   logic [CC_W-1:0] cc_word;
   logic [XLEN-1:0] reg_val, trap_a, trap_b;
   logic [AW-1:0] pc;
   logic [DW-1:0] disp;
   logic [IW-1:0] trap_imm;
   logic res_valid, res_taken, res_mispredict, res_bp_update, res_trap;
   logic [AW-1:0] res_next_pc;
   logic [TW-1:0] res_trap_num;

   cond_xfer_resolver uut (.*);

   int n_run = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit ref_int(input logic [3:0] s, input logic [3:0] f);
      bit c = f[0], v = f[1], z = f[2], n = f[3];
      case (s)
         0: return 0;            8:  return 1;
         1: return z;            9:  return !z;
         2: return z | (n ^ v);  10: return !(z | (n ^ v));
         3: return n ^ v;        11: return !(n ^ v);
         4: return c | z;        12: return !(c | z);
         5: return c;            13: return !c;
         6: return n;            14: return !n;
         default: return (s == 7) ? v : !v;
      endcase
   endfunction

   function automatic bit ref_fp(input logic [3:0] s, input logic [1:0] r);
      bit e = (r == 0), l = (r == 1), g = (r == 2), u = (r == 3);
      case (s)
         0: return 0;         1: return l | g | u;  2: return l | g;      3: return u | l;
         4: return l;         5: return u | g;      6: return g;          7: return u;
         8: return 1;         9: return e;          10: return u | e;     11: return g | e;
         12: return u | g | e; 13: return l | e;    14: return u | l | e; default: return e | l | g;
      endcase
   endfunction

   function automatic bit ref_reg(input logic [2:0] s, input logic signed [XLEN-1:0] x);
      case (s)
         1: return x == 0;  2: return x <= 0;  3: return x < 0;
         5: return x != 0;  6: return x > 0;   7: return x >= 0;
         default: return 0;
      endcase
   endfunction

   task automatic run(input logic [1:0] k, input logic [3:0] s, input bit w,
                      input logic [CC_W-1:0] cc, input logic [1:0] fr,
                      input logic [XLEN-1:0] rv, input logic [AW-1:0] p,
                      input logic [DW-1:0] d, input bit pr,
                      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                      input logic [IW-1:0] im, input bit ui);
      bit et, emis, eupd, etrap;
      logic [3:0] nib;
      logic [AW-1:0] enpc;
      logic [XLEN-1:0] opnd;
      logic [TW-1:0] enum_t;
      logic [AW-1:0] pt;
      logic [TW-1:0] ptn;
      @(negedge clk);
      req_valid = 1; req_kind = k; cond_sel = s; wide_flags = w; cc_word = cc; fcmp = fr;
      reg_val = rv; pc = p; disp = d; pred_taken = pr; trap_a = a; trap_b = b;
      trap_imm = im; trap_use_imm = ui;
      nib = w ? cc[WS +: 4] : cc[3:0];
      case (k)
         0, 3: et = ref_int(s, nib);
         1: et = ref_fp(s, fr);
         default: et = ref_reg(s[2:0], rv);
      endcase
      if (k == 3) enpc = p + 4;
      else if (et) enpc = p + AW'(signed'(d)) * 4;
      else enpc = p + 8;
      emis  = (k != 3) && (et != pr);
      eupd  = (k == 2) || (k < 2 && s != 0);
      etrap = (k == 3) && et;
      opnd  = ui ? XLEN'(signed'(im)) : b;
      enum_t = TW'(TB) + TW'(a + opnd);
      @(negedge clk);
      req_valid = 0;
      chk("R8 valid", res_valid, 1);
      case (k)
         0: chk("R1 int taken", res_taken, et);
         1: chk("R2 fp taken", res_taken, et);
         2: chk("R3 reg taken", res_taken, et);
         default: chk("R7 trap cond", res_taken, et);
      endcase
      chk("R4 next pc", res_next_pc, enpc);
      chk("R5 mispredict", res_mispredict, emis);
      chk("R6 update", res_bp_update, eupd);
      chk("R7 trap", res_trap, etrap);
      if (k == 3) chk("R7 trap num", res_trap_num, enum_t);
      pt = res_next_pc; ptn = res_trap_num;
      // R8: idle cycle, everything holds and strobe drops
      req_kind = ~k; cond_sel = ~s; pc = ~p; pred_taken = ~pr;
      @(negedge clk);
      chk("R8 strobe low", res_valid, 0);
      chk("R8 hold pc", res_next_pc, pt);
      chk("R8 hold taken", res_taken, et);
      chk("R8 hold num", res_trap_num, ptn);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1; req_valid = 0; req_kind = 0; cond_sel = 0; wide_flags = 0; cc_word = 0;
      fcmp = 0; reg_val = 0; pc = 0; disp = 0; pred_taken = 0; trap_a = 0; trap_b = 0;
      trap_imm = 0; trap_use_imm = 0;
      repeat (3) @(negedge clk);
      chk("R9 reset valid", res_valid, 0);
      chk("R9 reset mispredict", res_mispredict, 0);
      chk("R9 reset update", res_bp_update, 0);
      chk("R9 reset trap", res_trap, 0);
      chk("R9 reset pc", res_next_pc, 0);
      rst = 0;

      // R1: every integer selector against narrow and wide nibbles that differ
      for (int s = 0; s < 16; s++)
         for (int f = 0; f < 16; f += 5) begin
            run(0, s[3:0], 0, {12'h0, 4'(~f), 12'h0, 4'(f)}, 0, 0, 32'h1000, 22'd16, 0, 0, 0, 0, 0);
            run(0, s[3:0], 1, {12'h0, 4'(f), 12'h0, 4'(~f)}, 0, 0, 32'h1000, -22'sd3, 1, 0, 0, 0, 0);
         end
      // R2: exhaustive floating selectors and results
      for (int s = 0; s < 16; s++)
         for (int r = 0; r < 4; r++)
            run(1, s[3:0], 0, 0, r[1:0], 0, 32'h2000, 22'h3FFFFF, r[0], 0, 0, 0, 0);
      // R3: register codes at zero, plus one, minus one and the most negative value
      for (int s = 0; s < 16; s++) begin
         run(2, s[3:0], 0, 0, 0, 64'd0, 32'h300, 22'd5, 1, 0, 0, 0, 0);
         run(2, s[3:0], 0, 0, 0, 64'd1, 32'h300, 22'd5, 0, 0, 0, 0, 0);
         run(2, s[3:0], 0, 0, 0, '1, 32'h300, 22'd5, 1, 0, 0, 0, 0);
         run(2, s[3:0], 0, 0, 0, {1'b1, 63'd0}, 32'h300, 22'd5, 0, 0, 0, 0, 0);
      end
      // R4: most negative displacement wraps below the pc
      run(0, 4'd8, 0, 0, 0, 0, 32'h10, {1'b1, 21'd0}, 1, 0, 0, 0, 0);
      // R7: trap with register operand, with negative immediate, and with a false condition
      run(3, 4'd8, 0, 0, 0, 0, 32'h44, 0, 0, 64'd5, 64'd250, 0, 0);
      run(3, 4'd1, 0, 32'h4, 0, 0, 32'h44, 0, 0, 64'd9, 64'd1, -13'sd2, 1);
      run(3, 4'd1, 0, 32'h0, 0, 0, 32'h44, 0, 1, 64'd9, 64'd1, 13'd7, 1);
      run(3, 4'd0, 1, '1, 0, 0, 32'h44, 0, 1, 64'd3, 64'd4, 13'd7, 0);

      // random mix over all kinds
      for (int i = 0; i < 600; i++)
         run($urandom_range(0, 3), 4'($urandom), 1'($urandom), $urandom, 2'($urandom),
             {$urandom, $urandom} >> $urandom_range(0, 63), $urandom, 22'($urandom), 1'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom}, 13'($urandom), 1'($urandom));

      // R9: reset mid-stream clears the sticky outputs
      run(0, 4'd8, 0, 0, 0, 0, 32'h80, 22'd1, 0, 0, 0, 0, 0);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      chk("R9 reset clears mispredict", res_mispredict, 0);
      chk("R9 reset clears update", res_bp_update, 0);
      chk("R9 reset clears pc", res_next_pc, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule